// File: doc/BRIEF.md
# Reference Clock Rate Classifier

This block watches one reference clock from inside the master clock domain and works out which of seven telecom rates is present: 2 kHz, 8 kHz, 1.544 MHz, 2.048 MHz, 8.192 MHz, 16.384 MHz or 19.44 MHz. The reference first passes through a synchroniser. Only its rising edges are used. The block then counts the master clock ticks between one edge and the next.

Periods are gathered in groups of eight. The total of a group selects the nearest nominal rate. That rate is locked only when every period in the group lies inside the acceptance window for that rate. Once a rate is locked, the same window is used to check every later period, so the block also acts as a single-cycle monitor. A reference that stops for longer than the loss timeout drops the lock and raises the fail flag. The locked rate also tells the loop which bandwidth to use: the 2 kHz rate needs the narrow one and every other rate uses the wide one.

The tick length and the loss timeout are parameters, given in picoseconds. All window limits and decision bands are derived from them when the block is elaborated.

Top module: `refclk_rate_detect`

## Requirements
- R1: After reset rate_valid is 0, rate_code is 7 (no rate), cycle_fail is 0 and bw_narrow is 0.
- R2: The reference passes through a synchroniser and only rising edges are used. A period is the number of ticks between two detected rising edges. The first edge after reset or after a loss only starts the timing.
- R3: Codes are 0 for 2 kHz, 1 for 8 kHz, 2 for 1.544 MHz, 3 for 2.048 MHz, 4 for 8.192 MHz, 5 for 16.384 MHz and 6 for 19.44 MHz. The sum of a group of eight periods picks the rate whose nominal eight-period length is nearest; each boundary lies halfway between two neighbouring nominal lengths.
- R4: A rate locks only if all eight periods of its group fall inside that rate's window. If any period falls outside, the whole group is discarded and a new group starts with the next period.
- R5: Seven periods or fewer never produce a lock.
- R6: While locked, rate_code does not change, even when periods typical of another rate arrive, until the clock is lost.
- R7: While locked, a period outside the window of the locked rate sets cycle_fail, and the next period inside the window clears it. The window runs from the minimum limit rounded down to whole ticks up to the maximum limit rounded up, both inclusive. With 50 ns ticks the 1.544 MHz window is 6 to 19 ticks.
- R8: If no rising edge arrives within the loss timeout after an edge (11,000 ticks by default), rate_valid falls, rate_code returns to 7 and cycle_fail rises. This state holds until the next lock.
- R9: bw_narrow is 1 only while locked to the 2 kHz rate.
- R10: After a loss the block can lock to a different rate, and a new lock clears cycle_fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one cycle is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| rate_code | output | 3 | Locked rate code, 7 when no rate is locked |
| rate_valid | output | 1 | A rate is locked |
| cycle_fail | output | 1 | Last period out of window, or reference lost |
| bw_narrow | output | 1 | Narrow loop bandwidth is required |

## Verification
The assertions take for granted that the reference stays high and stays low for at least one tick each, so that two detected rising edges are never adjacent. They also take for granted that periods are measured on ticks after reset has been released. The stimulus meets both conditions. It changes the reference only on the falling clock edge, drives a high of exactly one tick, and uses periods of two ticks or longer. Windows and bands for the two fastest rates are tested on a second copy of the block that uses a finer tick, because at 50 ns those two rates cannot be told apart from a single period.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

   localparam int NUM_RATES = 7;
   localparam int NUM_CODES = 8;

   typedef enum logic [2:0] {
      RATE_2K     = 3'd0,
      RATE_8K     = 3'd1,
      RATE_1M544  = 3'd2,
      RATE_2M048  = 3'd3,
      RATE_8M192  = 3'd4,
      RATE_16M384 = 3'd5,
      RATE_19M44  = 3'd6,
      RATE_NONE   = 3'd7
   } rate_e;

   // nominal period in ps
   function automatic longint nom_ps(input int k);
      case (k)
         0: nom_ps = 500_000_000;
         1: nom_ps = 125_000_000;
         2: nom_ps = 647_668;
         3: nom_ps = 488_281;
         4: nom_ps = 122_070;
         5: nom_ps = 61_035;
         6: nom_ps = 51_440;
         default: nom_ps = 0;
      endcase
   endfunction

   function automatic longint min_ps(input int k);
      case (k)
         0: min_ps = 483_000_000;
         1: min_ps = 120_000_000;
         2: min_ps = 338_000;
         3: min_ps = 263_000;
         4: min_ps = 63_000;
         5: min_ps = 38_000;
         6: min_ps = 38_000;
         default: min_ps = 0;
      endcase
   endfunction

   function automatic longint max_ps(input int k);
      case (k)
         0: max_ps = 516_000_000;
         1: max_ps = 128_000_000;
         2: max_ps = 950_000;
         3: max_ps = 712_000;
         4: max_ps = 175_000;
         5: max_ps = 75_000;
         6: max_ps = 75_000;
         default: max_ps = 0;
      endcase
   endfunction

   // window limits rounded outward to whole ticks
   function automatic longint lo_ticks(input int k, input longint tick);
      lo_ticks = min_ps(k) / tick;
   endfunction

   function automatic longint hi_ticks(input int k, input longint tick);
      hi_ticks = (max_ps(k) + tick - 1) / tick;
   endfunction

   // largest group sum that still belongs to rate k (k >= 1)
   function automatic longint band_ticks(input int k, input longint tick, input int grp);
      band_ticks = (longint'(grp) * (nom_ps(k) + nom_ps(k - 1))) / (2 * tick);
   endfunction

endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= ref_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;

   AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R2

endmodule

// File: rtl/refclk_period.sv
module refclk_period #(
   parameter int TIMEOUT = 11000,
   parameter int PW      = $clog2(TIMEOUT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise,
   output logic          period_valid,
   output logic [PW-1:0] period,
   output logic          loss
);

   logic [PW-1:0] cnt;
   logic          armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
         loss  <= 1'b0;
      end else begin
         loss <= 1'b0;
         if (rise) begin
            cnt   <= '0;
            armed <= 1'b1;
         end else if (armed) begin
            if (cnt == PW'(TIMEOUT - 1)) begin
               loss  <= 1'b1;
               armed <= 1'b0;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign period_valid = rise & armed;
   assign period       = cnt + 1'b1;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < PW'(TIMEOUT)); // R8

endmodule

// File: rtl/refclk_windows.sv
module refclk_windows
   import refclk_pkg::*;
#(
   parameter int TICK_PS = 50_000,
   parameter int PW      = 14
) (
   input  logic [PW-1:0]        period,
   output logic [NUM_CODES-1:0] in_win
);

   for (genvar k = 0; k < NUM_RATES; k++) begin : g_rate
      localparam logic [PW-1:0] LO = PW'(lo_ticks(k, longint'(TICK_PS)));
      localparam logic [PW-1:0] HI = PW'(hi_ticks(k, longint'(TICK_PS)));
      logic lo_ok;
      if (LO == '0) begin : g_open_low
         assign lo_ok = 1'b1;
      end else begin : g_cmp_low
         assign lo_ok = (period >= LO);
      end
      assign in_win[k] = lo_ok & (period <= HI);
   end

   assign in_win[NUM_CODES-1] = 1'b0;

endmodule

// File: rtl/refclk_classifier.sv
module refclk_classifier
   import refclk_pkg::*;
#(
   parameter int TICK_PS   = 50_000,
   parameter int GROUP_LEN = 8,
   parameter int PW        = 14,
   parameter int SW        = 17,
   parameter int GW        = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 period_valid,
   input  logic [PW-1:0]        period,
   input  logic [NUM_CODES-1:0] in_win,
   input  logic                 loss,
   output rate_e                rate,
   output logic                 locked,
   output logic                 fail
);

   logic [SW-1:0]        sum_q, sum_next;
   logic [NUM_CODES-1:0] mask_q, mask_next;
   logic [GW-1:0]        n_q;
   logic [NUM_RATES-1:1] below;
   rate_e                pick;
   logic                 agree, group_done;

   assign sum_next   = sum_q + SW'(period);
   assign mask_next  = mask_q & in_win;
   assign group_done = (n_q == GW'(GROUP_LEN - 1));

   for (genvar k = 1; k < NUM_RATES; k++) begin : g_band
      localparam logic [SW-1:0] BAND = SW'(band_ticks(k, longint'(TICK_PS), GROUP_LEN));
      assign below[k] = (sum_next <= BAND);
   end

   always_comb begin
      pick = RATE_2K;
      for (int k = 1; k < NUM_RATES; k++) begin
         if (below[k]) pick = rate_e'(3'(k));
      end
   end

   assign agree = mask_next[pick];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
         rate   <= RATE_NONE;
         fail   <= 1'b0;
         sum_q  <= '0;
         mask_q <= '1;
         n_q    <= '0;
      end else if (loss) begin
         locked <= 1'b0;
         rate   <= RATE_NONE;
         fail   <= 1'b1;
         sum_q  <= '0;
         mask_q <= '1;
         n_q    <= '0;
      end else if (period_valid) begin
         if (locked) begin
            fail <= ~in_win[rate];
         end else if (group_done) begin
            sum_q  <= '0;
            mask_q <= '1;
            n_q    <= '0;
            if (agree) begin
               locked <= 1'b1;
               rate   <= pick;
               fail   <= 1'b0;
            end
         end else begin
            sum_q  <= sum_next;
            mask_q <= mask_next;
            n_q    <= n_q + 1'b1;
         end
      end
   end

   AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(period_valid)); // R4

   AST_CLASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !loss) |=> (locked && $stable(rate))); // R6

   AST_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      loss |=> (!locked && fail)); // R8

endmodule

// File: rtl/refclk_rate_detect.sv
module refclk_rate_detect
   import refclk_pkg::*;
#(
   parameter int TICK_PS     = 50_000,
   parameter int LOSS_PS     = 550_000_000,
   parameter int GROUP_LEN   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_in,
   output logic [2:0] rate_code,
   output logic       rate_valid,
   output logic       cycle_fail,
   output logic       bw_narrow
);

   localparam int TIMEOUT = LOSS_PS / TICK_PS;
   localparam int PW      = $clog2(TIMEOUT + 1);
   localparam int SW      = $clog2(TIMEOUT * GROUP_LEN + 1);
   localparam int GW      = $clog2(GROUP_LEN + 1);

   logic                 rise, period_valid, loss;
   logic [PW-1:0]        period;
   logic [NUM_CODES-1:0] in_win;
   rate_e                rate;

   refclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rise(rise)
   );

   refclk_period #(.TIMEOUT(TIMEOUT), .PW(PW)) u_period (
      .clk(clk), .rst_n(rst_n), .rise(rise),
      .period_valid(period_valid), .period(period), .loss(loss)
   );

   refclk_windows #(.TICK_PS(TICK_PS), .PW(PW)) u_win (
      .period(period), .in_win(in_win)
   );

   refclk_classifier #(
      .TICK_PS(TICK_PS), .GROUP_LEN(GROUP_LEN), .PW(PW), .SW(SW), .GW(GW)
   ) u_cls (
      .clk(clk), .rst_n(rst_n), .period_valid(period_valid), .period(period),
      .in_win(in_win), .loss(loss), .rate(rate), .locked(rate_valid),
      .fail(cycle_fail)
   );

   assign rate_code = rate;
   assign bw_narrow = rate_valid && (rate == RATE_2K);

endmodule

// File: tb/sim_refclk_rate_detect.sv
module sim_refclk_rate_detect;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_a = 1'b0;
   logic ref_b = 1'b0;
   logic [2:0] code_a, code_b;
   logic valid_a, valid_b, fail_a, fail_b, bw_a, bw_b;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   refclk_rate_detect u0 (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_a), .rate_code(code_a),
      .rate_valid(valid_a), .cycle_fail(fail_a), .bw_narrow(bw_a)
   );

   refclk_rate_detect #(.TICK_PS(5_000)) u1 (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_b), .rate_code(code_b),
      .rate_valid(valid_b), .cycle_fail(fail_b), .bw_narrow(bw_b)
   );

   // period A for even intervals, period B for odd, expected code, expected bw
   localparam int NV = 7;
   localparam int V_PA[NV]   = '{10000, 2500, 13, 12, 10, 9, 3};
   localparam int V_PB[NV]   = '{10000, 2500, 13, 14, 10, 11, 2};
   localparam int V_CODE[NV] = '{0, 1, 2, 2, 3, 3, 4};
   localparam int V_BW[NV]   = '{1, 0, 0, 0, 0, 0, 0};

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ref_a = 1'b0;
      ref_b = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // rising edge now, next rising edge of the following call lands per ticks later
   task automatic pulse(input int sel, input int per);
      @(negedge clk);
      if (sel == 0) ref_a = 1'b1; else ref_b = 1'b1;
      @(negedge clk);
      if (sel == 0) ref_a = 1'b0; else ref_b = 1'b0;
      repeat (per - 2) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      do_reset();
      chk("R1", "valid", int'(valid_a), 0);
      chk("R1", "code", int'(code_a), 7);
      chk("R1", "fail", int'(fail_a), 0);
      chk("R1", "bw", int'(bw_a), 0);

      // vector table: one lock per entry
      for (int i = 0; i < NV; i++) begin
         do_reset();
         for (int j = 0; j < 8; j++) pulse(0, (j % 2 == 0) ? V_PA[i] : V_PB[i]);
         pulse(0, 2);
         repeat (6) @(negedge clk);
         chk("R3", "valid", int'(valid_a), 1);
         chk("R3", "code", int'(code_a), V_CODE[i]);
         chk("R9", "bw", int'(bw_a), V_BW[i]);
         chk("R7", "fail", int'(fail_a), 0);
      end

      // R4: one bad period spoils the group
      do_reset();
      pulse(0, 13); pulse(0, 13); pulse(0, 13); pulse(0, 25);
      pulse(0, 13); pulse(0, 13); pulse(0, 13); pulse(0, 13);
      pulse(0, 13);
      chk("R4", "valid after mixed group", int'(valid_a), 0);
      // R5: seven periods of the next group are not enough
      for (int j = 0; j < 7; j++) pulse(0, 13);
      chk("R5", "valid after 7 periods", int'(valid_a), 0);
      pulse(0, 13);
      chk("R4", "valid after clean group", int'(valid_a), 1);
      chk("R4", "code", int'(code_a), 2);

      // R6: 2.048 MHz periods do not change the locked class
      for (int j = 0; j < 9; j++) pulse(0, 10);
      chk("R6", "code held", int'(code_a), 2);
      chk("R6", "fail", int'(fail_a), 0);

      // R7: window checks on 6..19 ticks
      pulse(0, 25); pulse(0, 13);
      chk("R7", "fail long period", int'(fail_a), 1);
      chk("R7", "valid kept", int'(valid_a), 1);
      pulse(0, 13);
      chk("R7", "fail cleared", int'(fail_a), 0);
      pulse(0, 4); pulse(0, 13);
      chk("R7", "fail short period", int'(fail_a), 1);
      pulse(0, 19); pulse(0, 13);
      chk("R7", "fail at upper limit", int'(fail_a), 0);
      pulse(0, 20); pulse(0, 13);
      chk("R7", "fail above upper limit", int'(fail_a), 1);
      pulse(0, 6); pulse(0, 13);
      chk("R7", "fail at lower limit", int'(fail_a), 0);
      pulse(0, 5); pulse(0, 13);
      chk("R7", "fail below lower limit", int'(fail_a), 1);
      pulse(0, 13);
      chk("R7", "fail cleared again", int'(fail_a), 0);

      // R8: loss of clock
      repeat (10500) @(negedge clk);
      chk("R8", "valid before timeout", int'(valid_a), 1);
      chk("R8", "fail before timeout", int'(fail_a), 0);
      repeat (1000) @(negedge clk);
      chk("R8", "valid after loss", int'(valid_a), 0);
      chk("R8", "code after loss", int'(code_a), 7);
      chk("R8", "fail after loss", int'(fail_a), 1);
      chk("R9", "bw after loss", int'(bw_a), 0);

      // R10: relock to another rate after loss; R2: first edge only arms
      for (int j = 0; j < 8; j++) pulse(0, 10);
      repeat (6) @(negedge clk);
      chk("R2", "valid after 8 edges", int'(valid_a), 0);
      do_reset();
      for (int j = 0; j < 8; j++) pulse(0, 13);
      pulse(0, 2);
      repeat (6) @(negedge clk);
      chk("R10", "first lock", int'(code_a), 2);
      repeat (11500) @(negedge clk);
      chk("R10", "lost", int'(fail_a), 1);
      for (int j = 0; j < 8; j++) pulse(0, 10);
      pulse(0, 2);
      repeat (6) @(negedge clk);
      chk("R10", "relock valid", int'(valid_a), 1);
      chk("R10", "relock code", int'(code_a), 3);
      chk("R10", "relock fail", int'(fail_a), 0);

      // R3: fastest rates on the fine-tick copy
      do_reset();
      for (int j = 0; j < 8; j++) pulse(1, 10);
      pulse(1, 2);
      repeat (6) @(negedge clk);
      chk("R3", "fine valid 19.44", int'(valid_b), 1);
      chk("R3", "fine code 19.44", int'(code_b), 6);
      do_reset();
      for (int j = 0; j < 8; j++) pulse(1, 12);
      pulse(1, 2);
      repeat (6) @(negedge clk);
      chk("R3", "fine code 16.384", int'(code_b), 5);
      chk("R9", "fine bw 16.384", int'(bw_b), 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule